// File: doc/BRIEF.md
# Wormhole Switch Allocator

This block is the allocation and crossbar steering core of a five-port wormhole router. The ports are north, south, east, west and the local processing element. Each input port feeds two independent lanes, and each lane owns a sixteen-entry flit queue. Every cycle a port may push one flit into one of its lanes. The allocator then picks a winner in two round-robin stages. The first stage chooses one lane per input port. The second stage chooses one input port per output among those asking for it.

A winning packet keeps its input-to-output connection from its head flit through its tail flit. While the connection is held, the crossbar moves one flit per cycle whenever the downstream side is ready. The route for a packet is worked out upstream and carried in the head flit, so the block only reads the output number from it. Outputs that do not collide are served in parallel, so two packets heading to different outputs move in the same cycle.

Top module: `wormSwitchAlloc`

## Requirements
- R1: After reset no output carries a flit (every output strobe bit is 0) and every lane reports free space.
- R2: A flit is 39 bits: bit 38 is the strobe (flit present), bit 32 marks a head flit, bit 33 marks a tail flit, bits 36:34 hold the output number of a head flit (0 north, 1 south, 2 east, 3 west, 4 local), and bits 31:0 are payload. A flit is forwarded unchanged with bit 38 set. With the target output idle and ready, a head flit driven in cycle n is on that output in cycle n+2.
- R3: Once a head flit has won an output, that output carries only flits of that packet until its tail flit has passed. A packet from another port that wants the same output waits. The output-number bits of non-head flits are ignored.
- R4: The grant is released in the cycle the tail flit crosses. A waiting packet's head flit then appears two cycles after that tail flit.
- R5: Among input ports competing for one output, the search starts just past the port last granted that output (port 0 first after reset). The pointer advances only when a new packet is granted.
- R6: Among the lanes of one port, the search starts just past the lane last granted on that port (lane 0 first after reset). The pointer advances only when a new packet is granted.
- R7: Packets from different input ports to different outputs are granted and forwarded in the same cycle.
- R8: A lane never requests an output whose ready input is low, and no flit appears on an output while its ready input is low.
- R9: Each lane queue holds 16 flits in order. Its free-space output goes low when it is full, and a flit pushed into a full lane is dropped. The other lane of the port is not affected.
- R10: The output lane signal carries the lane index from which the present flit was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inFlit | input | 195 | Five 39-bit input flits, port p at bits p*39 upward; bit 38 of each writes it |
| inLane | input | 5 | Target lane for each input port's flit |
| laneSpace | output | 10 | Lane p*2+l has room for another flit |
| outReady | input | 5 | Downstream side of each output can take a flit this cycle |
| outFlit | output | 195 | Five 39-bit output flits, strobe bit set when a flit is present |
| outLane | output | 5 | Source lane of each output flit |

## Verification
A flit written at a clock edge is in its lane queue from that edge. The grant is registered at the next edge, and the flit is shown on the output during the following cycle. The head latency is therefore two cycles, later flits of a held packet follow one per cycle, and a waiting packet's head comes two cycles after the tail of the packet ahead of it. The bench tags every observed flit with the cycle in which it is sampled, a quarter period before the edge that consumes it. The directed checks compare those tags against cycle numbers derived from these rules. The random traffic is checked flit by flit against per-lane expected queues and per-output packet ownership, independent of cycle timing.

// File: rtl/swalloc_pkg.sv
package swalloc_pkg;
  localparam int NUM_PORTS   = 5;
  localparam int NUM_LANES   = 2;
  localparam int DATA_W      = 32;
  localparam int CTRL_W      = 6;
  localparam int FLIT_W      = DATA_W + CTRL_W + 1;
  localparam int PORT_W      = $clog2(NUM_PORTS);
  localparam int LANE_W      = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
  localparam int LANES_TOTAL = NUM_PORTS * NUM_LANES;

  // field positions inside a flit
  localparam int HEAD_BIT   = DATA_W;
  localparam int TAIL_BIT   = DATA_W + 1;
  localparam int DEST_LO    = DATA_W + 2;
  localparam int STROBE_BIT = FLIT_W - 1;

  typedef logic [FLIT_W-1:0] flit_t;
  typedef logic [PORT_W-1:0] portIdx_t;
  typedef logic [LANE_W-1:0] laneIdx_t;

  // strobes from the allocator to the datapath
  typedef struct packed {
    logic     [NUM_PORTS-1:0]   fire;
    portIdx_t [NUM_PORTS-1:0]   srcPort;
    laneIdx_t [NUM_PORTS-1:0]   srcLane;
    logic     [LANES_TOTAL-1:0] pop;
  } xbarCtl_t;
endpackage

// File: rtl/laneFifo.sv
module laneFifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 39
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             wrOk, rdOk;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign wrOk   = wrEn && !full;
  assign rdOk   = rdEn && !empty;
  assign rdData = mem[rdPtr];

  function automatic logic [AW-1:0] stepPtr(input logic [AW-1:0] ptr);
    return (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wrOk) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wrOk) wrPtr <= stepPtr(wrPtr);
      if (rdOk) rdPtr <= stepPtr(rdPtr);
      case ({wrOk, rdOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && full && !rdEn) |=> full); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> !empty); // R9
endmodule

// File: rtl/swAllocDp.sv
module swAllocDp
  import swalloc_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  flit_t    [NUM_PORTS-1:0]          inFlit,
  input  laneIdx_t [NUM_PORTS-1:0]          inLane,
  input  xbarCtl_t                          ctl,
  output flit_t    [LANES_TOTAL-1:0]        headFlit,
  output logic     [LANES_TOTAL-1:0]        laneNotEmpty,
  output logic     [LANES_TOTAL-1:0]        laneSpace,
  output flit_t    [NUM_PORTS-1:0]          outFlit,
  output laneIdx_t [NUM_PORTS-1:0]          outLane
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      localparam int IDX = p * NUM_LANES + l;
      logic wrEn, emptyQ, fullQ;
      assign wrEn = inFlit[p][STROBE_BIT] && (inLane[p] == laneIdx_t'(l));
      laneFifo #(.DEPTH(FIFO_DEPTH), .WIDTH(FLIT_W)) u_fifo (
        .clk    (clk),
        .rstN   (rstN),
        .wrEn   (wrEn),
        .wrData (inFlit[p]),
        .rdEn   (ctl.pop[IDX]),
        .rdData (headFlit[IDX]),
        .empty  (emptyQ),
        .full   (fullQ)
      );
      assign laneNotEmpty[IDX] = !emptyQ;
      assign laneSpace[IDX]    = !fullQ;
    end
  end

  // crossbar: every output picks the head of the lane its grant points at
  always_comb begin
    for (int o = 0; o < NUM_PORTS; o++) begin
      int src;
      src = int'(ctl.srcPort[o]) * NUM_LANES + int'(ctl.srcLane[o]);
      outFlit[o] = '0;
      outLane[o] = '0;
      if (ctl.fire[o]) begin
        outFlit[o]             = headFlit[src];
        outFlit[o][STROBE_BIT] = 1'b1;
        outLane[o]             = ctl.srcLane[o];
      end
    end
  end
endmodule

// File: rtl/swAllocCtrl.sv
module swAllocCtrl
  import swalloc_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  flit_t [LANES_TOTAL-1:0]    headFlit,
  input  logic  [LANES_TOTAL-1:0]    laneNotEmpty,
  input  logic  [NUM_PORTS-1:0]      outReady,
  output xbarCtl_t                   ctl
);
  // held grant state
  logic     [NUM_PORTS-1:0] portActive;
  laneIdx_t [NUM_PORTS-1:0] portLane;
  laneIdx_t [NUM_PORTS-1:0] lanePtr;
  logic     [NUM_PORTS-1:0] outBusy;
  portIdx_t [NUM_PORTS-1:0] outOwner;
  portIdx_t [NUM_PORTS-1:0] portPtr;

  // arbitration wires
  logic     [LANES_TOTAL-1:0] laneReq;
  logic     [NUM_PORTS-1:0]   portReqValid;
  laneIdx_t [NUM_PORTS-1:0]   portReqLane;
  portIdx_t [NUM_PORTS-1:0]   portReqOut;
  logic     [NUM_PORTS-1:0]   grantValid;
  portIdx_t [NUM_PORTS-1:0]   grantPort;
  logic     [NUM_PORTS-1:0]   portGrant;
  logic     [NUM_PORTS-1:0]   fire;
  logic     [NUM_PORTS-1:0]   tailSeen;
  logic     [LANES_TOTAL-1:0] pop;
  logic     [NUM_PORTS-1:0]   ownVec [NUM_PORTS];

  // a lane may ask only with a head flit, a free port and a ready, idle output
  always_comb begin
    for (int i = 0; i < LANES_TOTAL; i++) begin
      portIdx_t d;
      d = headFlit[i][DEST_LO +: PORT_W];
      laneReq[i] = 1'b0;
      if (laneNotEmpty[i] && headFlit[i][HEAD_BIT] && !portActive[i / NUM_LANES]
          && (int'(d) < NUM_PORTS))
        laneReq[i] = outReady[d] && !outBusy[d];
    end
  end

  // stage one: round robin over the lanes of each port
  always_comb begin
    portReqValid = '0;
    portReqLane  = '0;
    portReqOut   = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      for (int k = 0; k < NUM_LANES; k++) begin
        int idx;
        idx = int'(lanePtr[p]) + k;
        if (idx >= NUM_LANES) idx = idx - NUM_LANES;
        if (!portReqValid[p] && laneReq[p * NUM_LANES + idx]) begin
          portReqValid[p] = 1'b1;
          portReqLane[p]  = laneIdx_t'(idx);
          portReqOut[p]   = headFlit[p * NUM_LANES + idx][DEST_LO +: PORT_W];
        end
      end
    end
  end

  // stage two: round robin over the ports asking for each output
  always_comb begin
    grantValid = '0;
    grantPort  = '0;
    for (int o = 0; o < NUM_PORTS; o++) begin
      for (int k = 0; k < NUM_PORTS; k++) begin
        int idx;
        idx = int'(portPtr[o]) + k;
        if (idx >= NUM_PORTS) idx = idx - NUM_PORTS;
        if (!grantValid[o] && portReqValid[idx] && (portReqOut[idx] == portIdx_t'(o))) begin
          grantValid[o] = 1'b1;
          grantPort[o]  = portIdx_t'(idx);
        end
      end
    end
  end

  always_comb begin
    portGrant = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      for (int o = 0; o < NUM_PORTS; o++)
        if (grantValid[o] && (grantPort[o] == portIdx_t'(p))) portGrant[p] = 1'b1;
  end

  // flit movement over held grants
  always_comb begin
    pop = '0;
    for (int o = 0; o < NUM_PORTS; o++) begin
      int src;
      src = int'(outOwner[o]) * NUM_LANES + int'(portLane[outOwner[o]]);
      fire[o]     = outBusy[o] && laneNotEmpty[src] && outReady[o];
      tailSeen[o] = fire[o] && headFlit[src][TAIL_BIT];
      if (fire[o]) pop[src] = 1'b1;
    end
  end

  always_comb begin
    ctl.fire = fire;
    ctl.pop  = pop;
    for (int o = 0; o < NUM_PORTS; o++) begin
      ctl.srcPort[o] = outOwner[o];
      ctl.srcLane[o] = portLane[outOwner[o]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portActive <= '0;
      portLane   <= '0;
      lanePtr    <= '0;
      outBusy    <= '0;
      outOwner   <= '0;
      portPtr    <= '0;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (portGrant[p]) begin
          portActive[p] <= 1'b1;
          portLane[p]   <= portReqLane[p];
          lanePtr[p]    <= (portReqLane[p] == laneIdx_t'(NUM_LANES - 1)) ? '0
                           : portReqLane[p] + 1'b1;
        end
      end
      for (int o = 0; o < NUM_PORTS; o++) begin
        if (grantValid[o]) begin
          outBusy[o]  <= 1'b1;
          outOwner[o] <= grantPort[o];
          portPtr[o]  <= (grantPort[o] == portIdx_t'(NUM_PORTS - 1)) ? '0
                         : grantPort[o] + 1'b1;
        end else if (tailSeen[o]) begin
          outBusy[o]               <= 1'b0;
          portActive[outOwner[o]]  <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++)
      for (int o = 0; o < NUM_PORTS; o++)
        ownVec[p][o] = outBusy[o] && (outOwner[o] == portIdx_t'(p));
  end

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_outChk
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (outBusy[o] && !tailSeen[o]) |=> (outBusy[o] && $stable(outOwner[o]))); // R3
    AST_TAIL_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
      tailSeen[o] |=> !outBusy[o]); // R4
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_portChk
    AST_ONE_OUTPUT_PER_PORT: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(ownVec[p])); // R3
  end
endmodule

// File: rtl/wormSwitchAlloc.sv
module wormSwitchAlloc
  import swalloc_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_PORTS*FLIT_W-1:0]   inFlit,
  input  logic [NUM_PORTS*LANE_W-1:0]   inLane,
  output logic [LANES_TOTAL-1:0]        laneSpace,
  input  logic [NUM_PORTS-1:0]          outReady,
  output logic [NUM_PORTS*FLIT_W-1:0]   outFlit,
  output logic [NUM_PORTS*LANE_W-1:0]   outLane
);
  flit_t [LANES_TOTAL-1:0] headFlit;
  logic  [LANES_TOTAL-1:0] laneNotEmpty;
  xbarCtl_t                ctl;

  swAllocDp #(.FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .inFlit       (inFlit),
    .inLane       (inLane),
    .ctl          (ctl),
    .headFlit     (headFlit),
    .laneNotEmpty (laneNotEmpty),
    .laneSpace    (laneSpace),
    .outFlit      (outFlit),
    .outLane      (outLane)
  );

  swAllocCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .headFlit     (headFlit),
    .laneNotEmpty (laneNotEmpty),
    .outReady     (outReady),
    .ctl          (ctl)
  );

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_outPortChk
    AST_READY_GATE: assert property (@(posedge clk) disable iff (!rstN)
      outFlit[o*FLIT_W + STROBE_BIT] |-> outReady[o]); // R8
  end
endmodule

// File: tb/wormSwitchAlloc_bench.sv
module wormSwitchAlloc_bench;
  import swalloc_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NP = NUM_PORTS;
  localparam int NL = NUM_LANES;
  localparam int FW = FLIT_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP*FW-1:0] inFlit = '0;
  logic [NP*LANE_W-1:0] inLane = '0;
  logic [NP*NL-1:0] laneSpace;
  logic [NP-1:0] outReady = '1;
  logic [NP*FW-1:0] outFlit;
  logic [NP*LANE_W-1:0] outLane;

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  wormSwitchAlloc u_wormSwitchAlloc (
    .clk(clk), .rstN(rstN), .inFlit(inFlit), .inLane(inLane),
    .laneSpace(laneSpace), .outReady(outReady), .outFlit(outFlit), .outLane(outLane)
  );

  int nChecks = 0;
  int nFail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // flit layout per R2: payload = source port, lane, sequence number
  function automatic logic [FW-1:0] mkFlit(int src, int lane, int seq, bit hd, bit tl, int dest);
    logic [FW-1:0] f;
    f = '0;
    f[38]    = 1'b1;
    f[36:34] = 3'(dest);
    f[33]    = tl;
    f[32]    = hd;
    f[31:28] = 4'(src);
    f[27]    = 1'(lane);
    f[15:0]  = 16'(seq);
    return f;
  endfunction

  function automatic int fSrc(logic [FW-1:0] f);  return int'(f[31:28]); endfunction
  function automatic int fLane(logic [FW-1:0] f); return int'(f[27]);    endfunction
  function automatic int fSeq(logic [FW-1:0] f);  return int'(f[15:0]);  endfunction
  function automatic int fDest(logic [FW-1:0] f); return int'(f[36:34]); endfunction

  // expected per-lane queues
  logic [FW-1:0] expQ [NP][NL][64];
  int wp [NP][NL];
  int rp [NP][NL];
  int ownSrc [NP];

  // transfer log
  int logOut [4096];
  logic [FW-1:0] logFlit [4096];
  int logCyc [4096];
  int logN = 0;

  task automatic push(int p, int l, logic [FW-1:0] f);
    expQ[p][l][wp[p][l] % 64] = f;
    wp[p][l]++;
  endtask

  task automatic putRaw(int p, int l, logic [FW-1:0] f);
    inFlit[p*FW +: FW] = f;
    inLane[p*LANE_W +: LANE_W] = LANE_W'(l);
  endtask

  task automatic put(int p, int l, logic [FW-1:0] f);
    if (laneSpace[p*NL + l]) push(p, l, f);
    putRaw(p, l, f);
  endtask

  task automatic tick();
    @(negedge clk);
    inFlit = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    inFlit = '0;
    for (int p = 0; p < NP; p++) begin
      ownSrc[p] = -1;
      for (int l = 0; l < NL; l++) begin
        wp[p][l] = 0;
        rp[p][l] = 0;
      end
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic int findLog(int from, int out, int src, int seq);
    for (int i = from; i < logN; i++)
      if (logOut[i] == out && fSrc(logFlit[i]) == src && fSeq(logFlit[i]) == seq) return i;
    return -1;
  endfunction

  // monitor: samples a quarter period before the consuming edge
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rstN) begin
      for (int o = 0; o < NP; o++) begin
        logic [FW-1:0] f;
        f = outFlit[o*FW +: FW];
        if (f[38]) begin
          int s, l, key;
          s = fSrc(f);
          l = fLane(f);
          key = s * NL + l;
          if (logN < 4096) begin
            logOut[logN] = o; logFlit[logN] = f; logCyc[logN] = cyc; logN++;
          end
          if (s >= NP) check(1'b0, "R2", "source field", s, 0);
          else if (rp[s][l] < wp[s][l]) begin
            logic [FW-1:0] e;
            e = expQ[s][l][rp[s][l] % 64];
            rp[s][l]++;
            check(f == e, "R2", "forwarded flit", longint'(f), longint'(e));
          end else check(1'b0, "R9", "unexpected flit from lane", key, -1);
          check(int'(outLane[o*LANE_W +: LANE_W]) == l, "R10", "output lane",
                int'(outLane[o*LANE_W +: LANE_W]), l);
          if (ownSrc[o] < 0) begin
            check(f[32] == 1'b1, "R3", "packet opens with head", f[32], 1);
            check(fDest(f) == o, "R2", "head routed to its output", o, fDest(f));
            ownSrc[o] = f[33] ? -1 : key;
          end else begin
            check(ownSrc[o] == key && !f[32], "R3", "flit of held packet", key, ownSrc[o]);
            if (f[33]) ownSrc[o] = -1;
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog (all requirements): actual 0 expected 1");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  int remLen [NP][NL];
  int rDest [NP][NL];
  int seqCnt [NP][NL];

  initial begin
    int n, m, i0, a, b, c, cnt, lastSeq;
    bit allEmpty;
    int seedInit;
    seedInit = $urandom(32'd24681);
    for (int p = 0; p < NP; p++) ownSrc[p] = -1;
    doReset();

    // R1 reset state
    check(outFlit == '0, "R1", "outputs idle after reset", 0, 0);
    check(laneSpace == '1, "R1", "all lanes free after reset", laneSpace, 1023);

    // R2 latency of a lone head flit
    n = cyc; i0 = logN;
    put(0, 0, mkFlit(0, 0, 100, 1, 1, 3));
    tick(); repeat (4) tick();
    a = findLog(i0, 3, 0, 100);
    check(a >= 0 && logCyc[a] == n + 2, "R2", "head latency", (a >= 0) ? logCyc[a] - n : -1, 2);

    // R7 two inputs to two outputs together
    n = cyc; i0 = logN;
    put(1, 0, mkFlit(1, 0, 200, 1, 1, 0));
    put(2, 1, mkFlit(2, 1, 201, 1, 1, 4));
    tick(); repeat (4) tick();
    a = findLog(i0, 0, 1, 200);
    b = findLog(i0, 4, 2, 201);
    check(a >= 0 && b >= 0 && logCyc[a] == n + 2 && logCyc[b] == n + 2, "R7",
          "parallel delivery cycle", (b >= 0) ? logCyc[b] - n : -1, 2);

    // R5 port round robin on output 4, queued with ready low (R8)
    doReset();
    outReady = '0;
    i0 = logN;
    put(1, 0, mkFlit(1, 0, 300, 1, 1, 4));
    put(3, 0, mkFlit(3, 0, 301, 1, 1, 4));
    tick();
    put(1, 0, mkFlit(1, 0, 302, 1, 1, 4));
    put(3, 0, mkFlit(3, 0, 303, 1, 1, 4));
    tick(); repeat (3) tick();
    check(logN == i0, "R8", "no flit while ready low", logN - i0, 0);
    outReady = '1;
    repeat (16) tick();
    cnt = 0;
    for (int i = i0; i < logN; i++) if (logOut[i] == 4) begin
      int expSeq;
      expSeq = 300 + cnt;
      check(fSeq(logFlit[i]) == expSeq, "R5", "port grant order", fSeq(logFlit[i]), expSeq);
      cnt++;
    end
    check(cnt == 4, "R5", "packets on output 4", cnt, 4);

    // R6 lane round robin on port 2
    doReset();
    outReady = '0;
    i0 = logN;
    put(2, 0, mkFlit(2, 0, 400, 1, 1, 1)); tick();
    put(2, 1, mkFlit(2, 1, 401, 1, 1, 1)); tick();
    put(2, 0, mkFlit(2, 0, 402, 1, 1, 1)); tick();
    put(2, 1, mkFlit(2, 1, 403, 1, 1, 1)); tick();
    outReady = '1;
    repeat (16) tick();
    cnt = 0;
    for (int i = i0; i < logN; i++) if (logOut[i] == 1) begin
      int expSeq;
      expSeq = 400 + cnt;
      check(fSeq(logFlit[i]) == expSeq, "R6", "lane grant order", fSeq(logFlit[i]), expSeq);
      cnt++;
    end
    check(cnt == 4, "R6", "packets on output 1", cnt, 4);

    // R3 and R4: held packet with a gap, competitor waits; body dest field is junk
    doReset();
    outReady = '1;
    n = cyc; i0 = logN;
    put(0, 0, mkFlit(0, 0, 500, 1, 0, 2));
    put(4, 1, mkFlit(4, 1, 501, 1, 1, 2));
    tick(); repeat (3) tick();
    put(0, 0, mkFlit(0, 0, 502, 0, 1, 7));
    tick(); repeat (6) tick();
    a = findLog(i0, 2, 0, 500);
    b = findLog(i0, 2, 0, 502);
    c = findLog(i0, 2, 4, 501);
    check(a >= 0 && logCyc[a] == n + 2, "R3", "first head wins", (a >= 0) ? logCyc[a] - n : -1, 2);
    check(b >= 0 && c >= 0 && logCyc[c] > logCyc[b], "R3", "competitor after tail",
          (c >= 0) ? logCyc[c] : -1, (b >= 0) ? logCyc[b] + 2 : -1);
    check(b >= 0 && c >= 0 && logCyc[c] == logCyc[b] + 2, "R4", "release gap",
          (b >= 0 && c >= 0) ? logCyc[c] - logCyc[b] : -1, 2);

    // R8 ready gating of the request
    doReset();
    outReady = '1;
    outReady[1] = 1'b0;
    i0 = logN;
    put(3, 0, mkFlit(3, 0, 600, 1, 1, 1));
    tick(); repeat (5) tick();
    check(findLog(i0, 1, 3, 600) < 0, "R8", "held while ready low", 1, 0);
    m = cyc;
    outReady[1] = 1'b1;
    repeat (4) tick();
    a = findLog(i0, 1, 3, 600);
    check(a >= 0 && logCyc[a] == m + 1, "R8", "delivery after ready", (a >= 0) ? logCyc[a] - m : -1, 1);

    // R9 full lane drops extra flits
    doReset();
    outReady = '0;
    i0 = logN;
    for (int i = 0; i < 18; i++) begin
      logic [FW-1:0] f;
      f = mkFlit(1, 1, 700 + i, 1, 1, 0);
      if (i < 16) push(1, 1, f);
      putRaw(1, 1, f);
      tick();
    end
    check(laneSpace[3] == 1'b0, "R9", "full lane reports no space", laneSpace[3], 0);
    check(laneSpace[2] == 1'b1, "R9", "sibling lane unaffected", laneSpace[2], 1);
    outReady = '1;
    repeat (60) tick();
    cnt = 0; lastSeq = -1;
    for (int i = i0; i < logN; i++) if (logOut[i] == 0) begin
      cnt++;
      lastSeq = fSeq(logFlit[i]);
    end
    check(cnt == 16, "R9", "flits kept by full lane", cnt, 16);
    check(lastSeq == 715, "R9", "last kept flit", lastSeq, 715);
    check(laneSpace[3] == 1'b1, "R9", "space after drain", laneSpace[3], 1);

    // random traffic, checked by the monitor (R2 R3 R10)
    doReset();
    for (int p = 0; p < NP; p++)
      for (int l = 0; l < NL; l++) begin
        remLen[p][l] = 0;
        seqCnt[p][l] = 0;
      end
    for (int t = 0; t < 6000; t++) begin
      bit draining;
      draining = (t >= 4000);
      for (int o = 0; o < NP; o++) outReady[o] = draining ? 1'b1 : (($urandom % 4) != 0);
      for (int p = 0; p < NP; p++) begin
        if (($urandom % 2) == 1) begin
          int l;
          l = int'($urandom % NL);
          if (laneSpace[p*NL + l] && (remLen[p][l] > 0 || !draining)) begin
            bit hd;
            hd = 1'b0;
            if (remLen[p][l] == 0) begin
              remLen[p][l] = 1 + int'($urandom % 4);
              rDest[p][l] = int'($urandom % NP);
              hd = 1'b1;
            end
            put(p, l, mkFlit(p, l, seqCnt[p][l], hd, remLen[p][l] == 1, rDest[p][l]));
            seqCnt[p][l]++;
            remLen[p][l]--;
          end
        end
      end
      tick();
    end
    outReady = '1;
    repeat (100) tick();
    allEmpty = 1'b1;
    for (int p = 0; p < NP; p++)
      for (int l = 0; l < NL; l++)
        if (wp[p][l] != rp[p][l]) allEmpty = 1'b0;
    check(allEmpty, "R9", "every accepted flit delivered", allEmpty, 1);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule